// File: doc/BRIEF.md
# Burst Write Sequence Checker

This block sits beside a bus slave and watches the write beats that the slave accepts. Software first programs a start address, a start data word and a test length through a small 32-bit register port. From then on, every bus cycle that writes into the memory window is compared, beat by beat, against a predicted sequence. The predicted word address advances by one word on each beat. The predicted data is the previous predicted word rotated left by one bit.

A mismatch in the address raises a sticky address-error flag, and a mismatch in the data raises a separate sticky data-error flag. Both flags stay set until software writes all ones to the status register. A counter records how many bus cycles carried at least one checked beat. The beats reach the block over a snoop input that carries the cycle-active level, a valid strobe, the address and the data. The block only observes the bus; it never drives the slave's data lines.

Top module: `burst_seq_checker`

## Requirements
- R1: After reset, the status register, the burst counter, the test size and both start registers all read 0.
- R2: With register-port address bit 12 at 1, offset 0x018 holds the start address and offset 0x01C holds the start data, and both read back all 32 bits. Offset 0x014 holds the test size, which reads back only its low 11 bits, with the upper bits 0. Each access is acknowledged for one cycle, with read data valid in that cycle.
- R3: A register-port access with address bit 12 at 0 reads 0 and changes no register.
- R4: The expected address of beat k in a cycle keeps the start address bits 31:12 and 1:0 and has bits 11:2 equal to the start value plus k, modulo 1024. A mismatch sets status bit 1.
- R5: Beat 0 expects the start data. Each later beat expects the previous expected word rotated left by one bit. A mismatch sets status bit 0. Status bits 31:2 read 0.
- R6: The status flags are sticky. A later error-free cycle leaves them set, and a write of any value other than all ones to offset 0x020 leaves them set. A write of 0xFFFFFFFF to offset 0x020 clears both flags.
- R7: The burst counter (offset 0x010) increments by one when a bus cycle ends that held at least one checked beat. A write of 0xFFFFFFFF clears it to 0, and any other written value leaves it unchanged.
- R8: Each new bus cycle restarts the expected sequence from the programmed start address and start data.
- R9: Only the first test-size beats of a cycle are checked. Later beats never set a flag. A test size of 0 checks nothing and does not advance the counter.
- R10: A snooped beat whose address bit 12 is 1 is not checked, does not advance the sequence and does not count toward the burst counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_cyc | input | 1 | Register port cycle |
| reg_stb | input | 1 | Register port strobe |
| reg_we | input | 1 | Register port write enable |
| reg_adr | input | 13 | Register port byte address; bit 12 selects the registers |
| reg_wdat | input | 32 | Register port write data |
| reg_ack | output | 1 | Register port acknowledge, one cycle after the strobe |
| reg_rdat | output | 32 | Register port read data, valid with the acknowledge |
| snp_cyc | input | 1 | Snooped bus cycle active |
| snp_vld | input | 1 | Snooped beat accepted this cycle |
| snp_adr | input | 32 | Snooped beat address |
| snp_dat | input | 32 | Snooped beat write data |

## Verification
The bench builds the block with its default parameters: an 11-bit test size and a 16-bit burst counter. It programs a test length of 4 and a start address of 0xA0000FF8, so the word index wraps from 0x3FF to 0 inside a four-beat burst. An address error is injected on the beat that lands after the wrap. Bursts of 2 and 6 beats and a zero test length bring the restart and overrun paths within reach.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned REG_AW    = 13;
    localparam int unsigned SEL_BIT   = 12;

    localparam logic [11:0] OFS_CNT   = 12'h010;
    localparam logic [11:0] OFS_SIZE  = 12'h014;
    localparam logic [11:0] OFS_SADR  = 12'h018;
    localparam logic [11:0] OFS_SDAT  = 12'h01C;
    localparam logic [11:0] OFS_STAT  = 12'h020;

    typedef enum logic [2:0] {
        RID_NONE,
        RID_CNT,
        RID_SIZE,
        RID_SADR,
        RID_SDAT,
        RID_STAT
    } reg_id_t;

    // bit 1 = address sequence error, bit 0 = data sequence error
    typedef struct packed {
        logic adr_err;
        logic dat_err;
    } err_flags_t;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] adr;
        logic [WORD_W-1:0] dat;
    } beat_t;

    function automatic logic [WORD_W-1:0] rotl1(logic [WORD_W-1:0] v);
        return {v[WORD_W-2:0], v[WORD_W-1]};
    endfunction

    function automatic reg_id_t reg_decode(logic [REG_AW-1:0] a);
        reg_id_t id;
        id = RID_NONE;
        if (a[SEL_BIT]) begin
            case (a[11:0])
                OFS_CNT:  id = RID_CNT;
                OFS_SIZE: id = RID_SIZE;
                OFS_SADR: id = RID_SADR;
                OFS_SDAT: id = RID_SDAT;
                OFS_STAT: id = RID_STAT;
                default:  id = RID_NONE;
            endcase
        end
        return id;
    endfunction

endpackage

// File: rtl/bsc_regs.sv
module bsc_regs
    import bsc_pkg::*;
#(
    parameter int unsigned SIZE_W = 11,
    parameter int unsigned CNT_W  = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_cyc,
    input  logic                bus_stb,
    input  logic                bus_we,
    input  logic [REG_AW-1:0]   bus_adr,
    input  logic [WORD_W-1:0]   bus_wdat,
    output logic                bus_ack,
    output logic [WORD_W-1:0]   bus_rdat,
    input  err_flags_t          err_set,
    input  logic                burst_done,
    output logic [WORD_W-1:0]   start_adr,
    output logic [WORD_W-1:0]   start_dat,
    output logic [SIZE_W-1:0]   test_size
);

    localparam int unsigned SIZE_PAD = WORD_W - SIZE_W;
    localparam int unsigned CNT_PAD  = WORD_W - CNT_W;

    reg_id_t            rid;
    logic               acc, wr, all_ones, clr_stat, clr_cnt;
    logic [1:0]         stat_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [WORD_W-1:0]  rd_val;

    assign acc      = bus_cyc & bus_stb;
    assign wr       = acc & bus_we;
    assign rid      = reg_decode(bus_adr);
    assign all_ones = &bus_wdat;
    assign clr_stat = wr & (rid == RID_STAT) & all_ones;
    assign clr_cnt  = wr & (rid == RID_CNT)  & all_ones;

    always_comb begin
        case (rid)
            RID_CNT:  rd_val = {{CNT_PAD{1'b0}}, cnt_q};
            RID_SIZE: rd_val = {{SIZE_PAD{1'b0}}, test_size};
            RID_SADR: rd_val = start_adr;
            RID_SDAT: rd_val = start_dat;
            RID_STAT: rd_val = {{(WORD_W-2){1'b0}}, stat_q};
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_ack   <= 1'b0;
            bus_rdat  <= '0;
            start_adr <= '0;
            start_dat <= '0;
            test_size <= '0;
            stat_q    <= '0;
            cnt_q     <= '0;
        end else begin
            bus_ack  <= acc;
            bus_rdat <= (acc && !bus_we) ? rd_val : '0;
            if (wr && rid == RID_SADR) start_adr <= bus_wdat;
            if (wr && rid == RID_SDAT) start_dat <= bus_wdat;
            if (wr && rid == RID_SIZE) test_size <= bus_wdat[SIZE_W-1:0];
            stat_q <= (clr_stat ? 2'b00 : stat_q) | err_set;
            if (clr_cnt)         cnt_q <= '0;
            else if (burst_done) cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: flags persist unless cleared by an all-ones write
    p_adr_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (stat_q[1] && !clr_stat) |=> stat_q[1]);
    p_dat_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (stat_q[0] && !clr_stat) |=> stat_q[0]);
    // R7: counter moves only on a finished burst or a clear
    p_cnt_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!clr_cnt && !burst_done) |=> $stable(cnt_q));
    // R2: acknowledge only answers a request of the previous cycle
    p_ack_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
        bus_ack |-> $past(bus_cyc && bus_stb));

endmodule

// File: rtl/bsc_seq.sv
module bsc_seq
    import bsc_pkg::*;
#(
    parameter int unsigned SIZE_W = 11
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                snp_cyc,
    input  beat_t               beat,
    input  logic [WORD_W-1:0]   start_adr,
    input  logic [WORD_W-1:0]   start_dat,
    input  logic [SIZE_W-1:0]   test_size,
    output err_flags_t          err_set,
    output logic                burst_done
);

    localparam int unsigned IDX_W = 10;

    logic               cyc_q, started_q, hit_q;
    logic [SIZE_W-1:0]  cnt_q, cur_cnt;
    logic [IDX_W-1:0]   idx_q, cur_idx;
    logic [WORD_W-1:0]  dat_q, cur_dat, exp_adr;
    logic               in_ram, chk;

    assign in_ram  = snp_cyc & beat.vld & ~beat.adr[SEL_BIT];
    assign cur_cnt = started_q ? cnt_q : '0;
    assign cur_idx = started_q ? idx_q : start_adr[11:2];
    assign cur_dat = started_q ? dat_q : start_dat;
    assign exp_adr = {start_adr[WORD_W-1:12], cur_idx, start_adr[1:0]};
    assign chk     = in_ram & (cur_cnt < test_size);

    assign err_set.adr_err = chk & (beat.adr != exp_adr);
    assign err_set.dat_err = chk & (beat.dat != cur_dat);
    assign burst_done      = cyc_q & ~snp_cyc & hit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q     <= 1'b0;
            started_q <= 1'b0;
            hit_q     <= 1'b0;
            cnt_q     <= '0;
            idx_q     <= '0;
            dat_q     <= '0;
        end else begin
            cyc_q <= snp_cyc;
            if (!snp_cyc) begin
                started_q <= 1'b0;
                hit_q     <= 1'b0;
            end else if (chk) begin
                started_q <= 1'b1;
                hit_q     <= 1'b1;
                cnt_q     <= cur_cnt + 1'b1;
                idx_q     <= cur_idx + 1'b1;
                dat_q     <= rotl1(cur_dat);
            end
        end
    end

    // R8: a fresh cycle always starts from the programmed values
    p_fresh_cycle_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(snp_cyc) |-> !started_q);
    // R7: one count per finished cycle
    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        burst_done |=> !burst_done);

endmodule

// File: rtl/burst_seq_checker.sv
module burst_seq_checker
    import bsc_pkg::*;
#(
    parameter int unsigned SIZE_W = 11,
    parameter int unsigned CNT_W  = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_cyc,
    input  logic          reg_stb,
    input  logic          reg_we,
    input  logic [12:0]   reg_adr,
    input  logic [31:0]   reg_wdat,
    output logic          reg_ack,
    output logic [31:0]   reg_rdat,
    input  logic          snp_cyc,
    input  logic          snp_vld,
    input  logic [31:0]   snp_adr,
    input  logic [31:0]   snp_dat
);

    beat_t              beat;
    err_flags_t         err_set;
    logic               burst_done;
    logic [WORD_W-1:0]  start_adr, start_dat;
    logic [SIZE_W-1:0]  test_size;

    assign beat = '{vld: snp_vld, adr: snp_adr, dat: snp_dat};

    bsc_regs #(.SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_cyc    (reg_cyc),
        .bus_stb    (reg_stb),
        .bus_we     (reg_we),
        .bus_adr    (reg_adr),
        .bus_wdat   (reg_wdat),
        .bus_ack    (reg_ack),
        .bus_rdat   (reg_rdat),
        .err_set    (err_set),
        .burst_done (burst_done),
        .start_adr  (start_adr),
        .start_dat  (start_dat),
        .test_size  (test_size)
    );

    bsc_seq #(.SIZE_W(SIZE_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .snp_cyc    (snp_cyc),
        .beat       (beat),
        .start_adr  (start_adr),
        .start_dat  (start_dat),
        .test_size  (test_size),
        .err_set    (err_set),
        .burst_done (burst_done)
    );

endmodule

// File: tb/sim_burst_seq_checker.sv
module sim_burst_seq_checker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_cyc = 1'b0, reg_stb = 1'b0, reg_we = 1'b0;
    logic [12:0] reg_adr = '0;
    logic [31:0] reg_wdat = '0;
    logic        reg_ack;
    logic [31:0] reg_rdat;
    logic        snp_cyc = 1'b0, snp_vld = 1'b0;
    logic [31:0] snp_adr = '0, snp_dat = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    localparam logic [31:0] SA = 32'hA000_0FF8;
    localparam logic [31:0] SD = 32'h8000_0001;

    burst_seq_checker u0 (
        .clk(clk), .rst(rst),
        .reg_cyc(reg_cyc), .reg_stb(reg_stb), .reg_we(reg_we),
        .reg_adr(reg_adr), .reg_wdat(reg_wdat),
        .reg_ack(reg_ack), .reg_rdat(reg_rdat),
        .snp_cyc(snp_cyc), .snp_vld(snp_vld),
        .snp_adr(snp_adr), .snp_dat(snp_dat)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] rot(logic [31:0] v);
        return {v[30:0], v[31]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_cyc = 1'b1; reg_stb = 1'b1; reg_we = 1'b1; reg_adr = a; reg_wdat = d;
        @(negedge clk);
        reg_cyc = 1'b0; reg_stb = 1'b0; reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [12:0] a, output logic [31:0] d, output logic ak);
        @(negedge clk);
        reg_cyc = 1'b1; reg_stb = 1'b1; reg_we = 1'b0; reg_adr = a;
        @(negedge clk);
        d  = reg_rdat;
        ak = reg_ack;
        reg_cyc = 1'b0; reg_stb = 1'b0;
    endtask

    task automatic expect_reg(input string tag, input logic [12:0] a, input logic [31:0] exp);
        logic [31:0] d;
        logic ak;
        reg_rd(a, d, ak);
        check(tag, d, exp);
    endtask

    // n beats following the sequence; bad_a/bad_d corrupt one beat,
    // beats at or beyond junk get inverted data, hi sets address bit 12
    task automatic burst(input int n, input int bad_a, input int bad_d,
                         input int junk, input bit hi);
        logic [31:0] d;
        logic [9:0]  ix;
        d = SD;
        @(negedge clk);
        snp_cyc = 1'b1;
        for (int k = 0; k < n; k++) begin
            ix = SA[11:2] + 10'(k);
            snp_vld = 1'b1;
            snp_adr = {SA[31:12], ix, SA[1:0]};
            snp_dat = d;
            if (k == bad_a) snp_adr = snp_adr ^ 32'h4;
            if (k == bad_d) snp_dat = snp_dat ^ 32'h10;
            if (k >= junk)  begin snp_dat = ~d; snp_adr = snp_adr ^ 32'h80; end
            if (hi)         snp_adr[12] = 1'b1;
            d = rot(d);
            @(negedge clk);
        end
        snp_vld = 1'b0;
        snp_cyc = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset;
        expect_reg("R1 status", 13'h1020, 32'h0);
        expect_reg("R1 counter", 13'h1010, 32'h0);
        expect_reg("R1 size", 13'h1014, 32'h0);
        expect_reg("R1 start address", 13'h1018, 32'h0);
    endtask

    task automatic t_registers;
        logic [31:0] d;
        logic ak;
        reg_wr(13'h1018, SA);
        reg_wr(13'h101C, SD);
        reg_wr(13'h1014, 32'hFFFF_F804);
        reg_rd(13'h1018, d, ak);
        check("R2 start address", d, SA);
        check("R2 ack", {31'b0, ak}, 32'h1);
        expect_reg("R2 start data", 13'h101C, SD);
        expect_reg("R2 size low bits only", 13'h1014, 32'h0000_0004);
    endtask

    task automatic t_ram_window;
        reg_wr(13'h0018, 32'hDEAD_BEEF);
        expect_reg("R3 register unchanged", 13'h1018, SA);
        expect_reg("R3 window reads zero", 13'h0018, 32'h0);
    endtask

    task automatic t_clean;
        burst(4, -1, -1, 99, 1'b0);
        expect_reg("R4 R5 clean burst status", 13'h1020, 32'h0);
        expect_reg("R7 count after clean burst", 13'h1010, 32'd1);
    endtask

    task automatic t_restart;
        burst(2, -1, -1, 99, 1'b0);
        burst(4, -1, -1, 99, 1'b0);
        expect_reg("R8 restart no error", 13'h1020, 32'h0);
        expect_reg("R8 count", 13'h1010, 32'd3);
    endtask

    task automatic t_adr_err;
        burst(4, 2, -1, 99, 1'b0);
        expect_reg("R4 address error after wrap", 13'h1020, 32'h2);
        reg_wr(13'h1020, 32'hFFFF_FFFF);
        expect_reg("R6 cleared", 13'h1020, 32'h0);
    endtask

    task automatic t_dat_err;
        burst(4, -1, 1, 99, 1'b0);
        expect_reg("R5 data error", 13'h1020, 32'h1);
        burst(4, -1, -1, 99, 1'b0);
        expect_reg("R6 sticky over clean burst", 13'h1020, 32'h1);
        reg_wr(13'h1020, 32'h0000_0005);
        expect_reg("R6 partial write keeps flag", 13'h1020, 32'h1);
        reg_wr(13'h1020, 32'hFFFF_FFFF);
        expect_reg("R6 all ones clears", 13'h1020, 32'h0);
        expect_reg("R7 count", 13'h1010, 32'd6);
    endtask

    task automatic t_overrun;
        burst(6, -1, -1, 4, 1'b0);
        expect_reg("R9 beats past size ignored", 13'h1020, 32'h0);
        expect_reg("R9 overrun counted", 13'h1010, 32'd7);
        reg_wr(13'h1014, 32'h0);
        burst(3, -1, -1, 0, 1'b0);
        expect_reg("R9 size zero no error", 13'h1020, 32'h0);
        expect_reg("R9 size zero no count", 13'h1010, 32'd7);
        reg_wr(13'h1014, 32'h4);
    endtask

    task automatic t_high_window;
        burst(4, -1, -1, 0, 1'b1);
        expect_reg("R10 bit 12 beats unchecked", 13'h1020, 32'h0);
        expect_reg("R10 bit 12 beats uncounted", 13'h1010, 32'd7);
    endtask

    task automatic t_cnt_clear;
        reg_wr(13'h1010, 32'h0000_0005);
        expect_reg("R7 partial write keeps count", 13'h1010, 32'd7);
        reg_wr(13'h1010, 32'hFFFF_FFFF);
        expect_reg("R7 all ones clears count", 13'h1010, 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_registers;
        t_ram_window;
        t_clean;
        t_restart;
        t_adr_err;
        t_dat_err;
        t_overrun;
        t_high_window;
        t_cnt_clear;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule